// File: doc/BRIEF.md
# Three-Stage Instruction Pipeline Controller

This block holds the instruction registers of a small in-order 32-bit core and decides each clock whether the pipeline moves forward one slot, stays where it is, or throws away its contents. A fetch slot takes a word from memory through a request/acknowledge loop. The word lands in a first register and then moves unchanged into a second one. Nothing is parsed between the two. The word in the second register is the executing instruction. Its top four bits are compared with the status flags to decide whether it fires.

The execution units and the branch logic stay outside the block. They report three things: that the firing instruction is multicycle, that a multicycle unit has finished, and that the firing instruction writes the program counter, with the new target. A PC write empties both registers with all-zero words. A multicycle instruction is copied into a holding register. The pipeline then takes exactly one more slot and freezes until the unit reports completion. Any word that needs none of these treatments simply flows through, so an unrecognised word costs a single slot.

Top module: `insn_pipe3`

## Requirements
- R1: While reset is low, and on the first cycle after it, the PC is 0, the executing and held instructions are 0, and `fetchReq` is high.
- R2: An accepted fetch (`fetchReq` and `fetchAck` high, no flush) loads `fetchData` into the first register, moves the first register into `execInstr`, and adds 4 to the PC at that clock edge. Without an acknowledge, all three keep their values.
- R3: `execFire` is combinational. Take the code in `execInstr[31:28]` and the flags as `flags[3]`=N, `[2]`=Z, `[1]`=C, `[0]`=V. The codes then mean: 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C|Z, 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 Z|(N!=V), 14 always, 15 never.
- R4: An all-zero `execInstr` is a NOP: `execFire` stays low whatever the flags are.
- R5: If `pcWrite` is high while `execFire` is high, the next edge loads `pcTarget` into the PC and zero into both instruction registers. An acknowledge in that cycle is ignored.
- R6: `pcWrite` has no effect while `execFire` is low. The pipeline then behaves as in R2.
- R7: If `execMulti` is high while `execFire` is high at an accepted fetch, `holdInstr` takes the executing word and the pipeline advances that one slot. After that, `fetchReq` and `execFire` stay low, and the PC and `execInstr` stay frozen even with `fetchAck` high, until `unitDone`.
- R8: `unitDone` during the frozen phase makes `fetchReq` high again from the next edge and clears `holdInstr` to 0.
- R9: `execMulti` with a failed condition captures nothing and does not freeze the pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| fetchData | input | 32 | Instruction word returned by memory |
| fetchAck | input | 1 | Memory acknowledge for the current fetch |
| flags | input | 4 | Status flags N, Z, C, V (bit 3 down to bit 0) |
| pcWrite | input | 1 | The executing instruction changes the PC |
| pcTarget | input | 32 | New PC value for a PC write |
| execMulti | input | 1 | The executing instruction needs several cycles |
| unitDone | input | 1 | The multicycle unit has finished |
| fetchReq | output | 1 | Fetch request to memory |
| pc | output | 32 | Program counter, the fetch address |
| execInstr | output | 32 | Instruction in the execute stage |
| holdInstr | output | 32 | Copy of the multicycle instruction being finished |
| execFire | output | 1 | The executing instruction passes its condition |

## Verification
`execFire` and `fetchReq` are combinational, so they are due in the cycle in which their inputs are applied. The PC, `execInstr` and `holdInstr` change at the first rising edge that acts on a request. Each request therefore has a single-edge latency, and a word fetched at edge k shows up on `execInstr` at edge k+1. The bench applies stimulus on the falling edge and reads combinational outputs 1 ns later. It reads registered outputs 1 ns after the following rising edge and keeps a running model of the expected PC and the word queue. The condition table is swept over all 16 codes against all 16 flag patterns, with the words streamed back-to-back through the pipeline.

// File: rtl/insn_pipe3_pkg.sv
package insn_pipe3_pkg;

  // Strobes from control to the register datapath, one set per cycle.
  typedef struct packed {
    logic advance;   // shift fetch word in, PC forward
    logic flush;     // zero both stages, PC <= target
    logic holdLoad;  // copy execute word to holding register
    logic holdDrop;  // clear holding register
  } pipeStrobe_t;

  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_HOLD = 1'b1
  } pipeState_t;

endpackage

// File: rtl/insn_cond_eval.sv
module insn_cond_eval (
  input  logic [3:0] condCode,
  input  logic [3:0] flags,
  output logic       condMet
);
  logic fN, fZ, fC, fV;
  assign fN = flags[3];
  assign fZ = flags[2];
  assign fC = flags[1];
  assign fV = flags[0];

  always_comb begin
    unique case (condCode)
      4'd0:  condMet = fZ;
      4'd1:  condMet = !fZ;
      4'd2:  condMet = fC;
      4'd3:  condMet = !fC;
      4'd4:  condMet = fN;
      4'd5:  condMet = !fN;
      4'd6:  condMet = fV;
      4'd7:  condMet = !fV;
      4'd8:  condMet = fC && !fZ;
      4'd9:  condMet = !fC || fZ;
      4'd10: condMet = (fN == fV);
      4'd11: condMet = (fN != fV);
      4'd12: condMet = !fZ && (fN == fV);
      4'd13: condMet = fZ || (fN != fV);
      4'd14: condMet = 1'b1;
      default: condMet = 1'b0;
    endcase
  end
endmodule

// File: rtl/insn_pipe3_ctrl.sv
module insn_pipe3_ctrl
  import insn_pipe3_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        ir2Zero,
  input  logic        condMet,
  input  logic        fetchAck,
  input  logic        pcWrite,
  input  logic        execMulti,
  input  logic        unitDone,
  output pipeStrobe_t strobe,
  output logic        fetchReq,
  output logic        execFire
);
  pipeState_t state, stateNext;
  logic running;

  assign running  = (state == ST_RUN);
  assign fetchReq = running;
  assign execFire = running && !ir2Zero && condMet;

  always_comb begin
    strobe.flush    = execFire && pcWrite;
    strobe.advance  = running && fetchAck && !strobe.flush;
    strobe.holdLoad = strobe.advance && execMulti && execFire;
    strobe.holdDrop = !running && unitDone;
  end

  always_comb begin
    stateNext = state;
    if (strobe.holdLoad)      stateNext = ST_HOLD;
    else if (strobe.holdDrop) stateNext = ST_RUN;
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_RUN;
    else       state <= stateNext;
  end
endmodule

// File: rtl/insn_pipe3_dp.sv
module insn_pipe3_dp
  import insn_pipe3_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 32,
  parameter int PC_STEP  = 4,
  parameter int RESET_PC = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  pipeStrobe_t       strobe,
  input  logic [DATA_W-1:0] fetchData,
  input  logic [ADDR_W-1:0] pcTarget,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] ir2,
  output logic [DATA_W-1:0] holdReg,
  output logic              ir2Zero,
  output logic [3:0]        condCode
);
  localparam int COND_LSB = DATA_W - 4;
  localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(PC_STEP);
  localparam logic [ADDR_W-1:0] PC_RST = ADDR_W'(RESET_PC);

  logic [DATA_W-1:0] ir1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc  <= PC_RST;
      ir1 <= '0;
      ir2 <= '0;
    end else if (strobe.flush) begin
      pc  <= pcTarget;
      ir1 <= '0;
      ir2 <= '0;
    end else if (strobe.advance) begin
      pc  <= pc + STEP;
      ir1 <= fetchData;
      ir2 <= ir1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                holdReg <= '0;
    else if (strobe.holdLoad) holdReg <= ir2;
    else if (strobe.holdDrop) holdReg <= '0;
  end

  assign ir2Zero  = (ir2 == '0);
  assign condCode = ir2[COND_LSB +: 4];
endmodule

// File: rtl/insn_pipe3.sv
module insn_pipe3
  import insn_pipe3_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 32,
  parameter int PC_STEP  = 4,
  parameter int RESET_PC = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] fetchData,
  input  logic              fetchAck,
  input  logic [3:0]        flags,
  input  logic              pcWrite,
  input  logic [ADDR_W-1:0] pcTarget,
  input  logic              execMulti,
  input  logic              unitDone,
  output logic              fetchReq,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] execInstr,
  output logic [DATA_W-1:0] holdInstr,
  output logic              execFire
);
  pipeStrobe_t strobe;
  logic        ir2Zero;
  logic        condMet;
  logic [3:0]  condCode;

  insn_pipe3_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .ir2Zero(ir2Zero), .condMet(condMet),
    .fetchAck(fetchAck), .pcWrite(pcWrite), .execMulti(execMulti),
    .unitDone(unitDone), .strobe(strobe), .fetchReq(fetchReq),
    .execFire(execFire)
  );

  insn_pipe3_dp #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PC_STEP(PC_STEP), .RESET_PC(RESET_PC)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .fetchData(fetchData),
    .pcTarget(pcTarget), .pc(pc), .ir2(execInstr), .holdReg(holdInstr),
    .ir2Zero(ir2Zero), .condCode(condCode)
  );

  insn_cond_eval cond_i (
    .condCode(condCode), .flags(flags), .condMet(condMet)
  );
endmodule

// File: rtl/insn_pipe3_chk.sv
module insn_pipe3_chk #(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 32,
  parameter int PC_STEP = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              fetchAck,
  input logic              pcWrite,
  input logic [ADDR_W-1:0] pcTarget,
  input logic              execMulti,
  input logic              unitDone,
  input logic              fetchReq,
  input logic [ADDR_W-1:0] pc,
  input logic [DATA_W-1:0] execInstr,
  input logic [DATA_W-1:0] holdInstr,
  input logic              execFire
);
  AST_FETCH_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (fetchReq && fetchAck && !(pcWrite && execFire))
      |=> (pc == $past(pc) + ADDR_W'(PC_STEP)));  // R2

  AST_IDLE_PC: assert property (@(posedge clk) disable iff (!rstN)
    ((!fetchReq || !fetchAck) && !(pcWrite && execFire)) |=> $stable(pc));  // R2

  AST_FLUSH_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (pcWrite && execFire) |=> (execInstr == '0 && pc == $past(pcTarget)));  // R5

  AST_NOP_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (execInstr == '0) |-> !execFire);  // R4

  AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !fetchReq |-> !execFire);  // R7

  AST_HOLD_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    (fetchReq && fetchAck && execMulti && execFire && !pcWrite)
      |=> (!fetchReq && holdInstr == $past(execInstr)));  // R7

  AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (!fetchReq && unitDone) |=> (fetchReq && holdInstr == '0));  // R8
endmodule

bind insn_pipe3 insn_pipe3_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PC_STEP(PC_STEP)
) chk_i (
  .clk(clk), .rstN(rstN), .fetchAck(fetchAck), .pcWrite(pcWrite),
  .pcTarget(pcTarget), .execMulti(execMulti), .unitDone(unitDone),
  .fetchReq(fetchReq), .pc(pc), .execInstr(execInstr),
  .holdInstr(holdInstr), .execFire(execFire)
);

// File: tb/insn_pipe3_tb_top.sv
`timescale 1ns/1ps
module insn_pipe3_tb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] fetchData;
  logic        fetchAck;
  logic [3:0]  flags;
  logic        pcWrite;
  logic [31:0] pcTarget;
  logic        execMulti;
  logic        unitDone;
  logic        fetchReq;
  logic [31:0] pc;
  logic [31:0] execInstr;
  logic [31:0] holdInstr;
  logic        execFire;

  int nChecks = 0;
  int nFail   = 0;
  int cycles  = 0;
  bit ended   = 1'b0;
  logic [31:0] expPc;

  always #5 clk = ~clk;

  insn_pipe3 dut_i (
    .clk(clk), .rstN(rstN), .fetchData(fetchData), .fetchAck(fetchAck),
    .flags(flags), .pcWrite(pcWrite), .pcTarget(pcTarget),
    .execMulti(execMulti), .unitDone(unitDone), .fetchReq(fetchReq),
    .pc(pc), .execInstr(execInstr), .holdInstr(holdInstr), .execFire(execFire)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Condition meaning from the requirement table: even code = base test, odd = its inverse.
  function automatic logic expCond(input int code, input logic [3:0] f);
    logic n, z, c, v, base;
    n = f[3]; z = f[2]; c = f[1]; v = f[0];
    case (code / 2)
      0: base = z;
      1: base = c;
      2: base = n;
      3: base = v;
      4: base = c & ~z;
      5: base = ~(n ^ v);
      6: base = ~z & ~(n ^ v);
      default: base = 1'b1;
    endcase
    return (code % 2 == 1) ? ~base : base;
  endfunction

  task automatic setIdle();
    fetchAck = 1'b0; pcWrite = 1'b0; execMulti = 1'b0; unitDone = 1'b0;
  endtask

  task automatic afterEdge();
    @(posedge clk);
    #1;
  endtask

  // Plain accepted fetch of one word.
  task automatic push(input logic [31:0] w);
    @(negedge clk);
    setIdle();
    fetchData = w; fetchAck = 1'b1;
    afterEdge();
    expPc += 32'd4;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 60000 && !ended) begin
      ended = 1'b1;
      nChecks++; nFail++;
      $display("FAIL watchdog actual=%0d expected=<60000 cycles", cycles);
      summary();
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; fetchData = '0; flags = 4'b0100; pcTarget = '0;
    setIdle();
    expPc = 32'd0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 pc", pc, 32'd0);
    chk("R1 execInstr", execInstr, 32'd0);
    chk("R1 holdInstr", holdInstr, 32'd0);
    chk("R1 fetchReq", {31'd0, fetchReq}, 32'd1);
    chk("R4 zero word with Z set", {31'd0, execFire}, 32'd0);
    rstN = 1'b1;
    afterEdge();
    chk("R1 pc after release", pc, 32'd0);

    // R2: straight-line code
    for (int k = 0; k < 6; k++) begin
      push(32'hE1A0_0000 + 32'(k + 1));
      chk("R2 pc step", pc, expPc);
      chk("R2 execInstr", execInstr, (k >= 1) ? 32'hE1A0_0000 + 32'(k) : 32'd0);
    end
    @(negedge clk);
    setIdle(); fetchData = 32'hDEAD_BEEF;
    afterEdge();
    chk("R2 no ack pc", pc, expPc);
    chk("R2 no ack execInstr", execInstr, 32'hE1A0_0005);

    // R3: all codes against all flag patterns, streamed
    for (int i = 0; i < 258; i++) begin
      @(negedge clk);
      setIdle();
      fetchData = (i < 256) ? {4'(i / 16), 16'h0, 12'(i + 1)} : 32'hE000_0F00 + 32'(i);
      fetchAck = 1'b1;
      if (i >= 2) begin
        flags = 4'((i - 2) % 16);
        #1;
        chk($sformatf("R3 code %0d flags %b", (i - 2) / 16, flags),
            {31'd0, execFire}, {31'd0, expCond((i - 2) / 16, flags)});
      end
      afterEdge();
      expPc += 32'd4;
    end
    chk("R2 pc after sweep", pc, expPc);

    // R6: failed-condition PC write is ignored
    push(32'h1A00_0010);
    push(32'hE3A0_F0AA);
    @(negedge clk);
    setIdle();
    flags = 4'b0100; pcWrite = 1'b1; pcTarget = 32'h0000_0200;
    fetchAck = 1'b1; fetchData = 32'hE000_0111;
    #1;
    chk("R6 execFire low", {31'd0, execFire}, 32'd0);
    afterEdge();
    expPc += 32'd4;
    chk("R6 pc advanced", pc, expPc);
    chk("R6 execInstr advanced", execInstr, 32'hE3A0_F0AA);

    // R5: taken PC write flushes, ack ignored
    @(negedge clk);
    setIdle();
    flags = 4'b0000; pcWrite = 1'b1; pcTarget = 32'h0000_0100;
    fetchAck = 1'b1; fetchData = 32'hE000_0222;
    #1;
    chk("R5 execFire high", {31'd0, execFire}, 32'd1);
    afterEdge();
    expPc = 32'h0000_0100;
    chk("R5 pc target", pc, expPc);
    chk("R5 execInstr zero", execInstr, 32'd0);
    @(negedge clk);
    setIdle(); flags = 4'b0100;
    #1;
    chk("R4 flushed NOP silent", {31'd0, execFire}, 32'd0);
    push(32'hE000_0301);
    chk("R5 first register zeroed", execInstr, 32'd0);
    push(32'hE000_0302);
    chk("R5 refill", execInstr, 32'hE000_0301);
    chk("R5 pc after refill", pc, 32'h0000_0108);

    // R7: multicycle capture then freeze
    @(negedge clk);
    setIdle();
    flags = 4'b0000; execMulti = 1'b1; fetchAck = 1'b1; fetchData = 32'h0000_1234;
    afterEdge();
    expPc += 32'd4;
    chk("R7 holdInstr", holdInstr, 32'hE000_0301);
    chk("R7 slipped one slot", execInstr, 32'hE000_0302);
    chk("R7 pc after slot", pc, expPc);
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      fetchAck = 1'b1; execMulti = 1'b1; fetchData = 32'hBAD0_0000 + 32'(j);
      #1;
      chk("R7 fetchReq low", {31'd0, fetchReq}, 32'd0);
      chk("R7 execFire low", {31'd0, execFire}, 32'd0);
      afterEdge();
      chk("R7 pc frozen", pc, expPc);
      chk("R7 execInstr frozen", execInstr, 32'hE000_0302);
    end

    // R8: release
    @(negedge clk);
    setIdle(); unitDone = 1'b1;
    afterEdge();
    chk("R8 fetchReq back", {31'd0, fetchReq}, 32'd1);
    chk("R8 holdInstr cleared", holdInstr, 32'd0);
    chk("R8 pc unchanged", pc, expPc);
    push(32'hE000_0401);
    chk("R8 resumes", execInstr, 32'h0000_1234);

    // R9: multicycle flag with failed condition (EQ, Z clear)
    @(negedge clk);
    setIdle();
    flags = 4'b0000; execMulti = 1'b1; fetchAck = 1'b1; fetchData = 32'hE000_0402;
    #1;
    chk("R9 execFire low", {31'd0, execFire}, 32'd0);
    afterEdge();
    expPc += 32'd4;
    chk("R9 no capture", holdInstr, 32'd0);
    chk("R9 no freeze", {31'd0, fetchReq}, 32'd1);
    chk("R9 advanced", execInstr, 32'hE000_0401);
    chk("R9 pc", pc, expPc);

    @(negedge clk);
    setIdle();
    if (!ended) begin
      ended = 1'b1;
      summary();
      $finish;
    end
  end
endmodule